// File: doc/BRIEF.md
# DMA Bus Master Release Controller

This block sequences the system-side bus cycles of a DMA channel while it owns a shared system bus. Software loads a start address, a transfer count, a retry budget and a mode, then pulses a start strobe. The block takes ownership and runs one bus cycle per transfer: an optional address-setup phase, four transfer phases, and wait phases for as long as the ready input stays low. After each completed transfer it advances the address by a fixed step and counts the length down. In cycle-steal mode every transfer gets the setup phase. In burst mode only the first transfer gets it, plus any transfer that follows an address increment that carried out of bit 15.

Two external events can stop a run. A release request makes the block finish the cycle it is in and then drop ownership, or drop ownership at once if no cycle has begun. The run is then paused and continues on a resume strobe. A bus error ends the current transfer at once. The same transfer is then run again while the retry budget lasts. When the budget is spent, the block releases the bus and halts. The halt is carried into a separate local clock domain so that the local-side DMA can stop too.

Top module: `dma_bus_release`

## Requirements
- R1: After reset, bus_phase is IDLE (0), bus_own, err_flag and local_halt are 0.
- R2: A start with a non-zero length moves to OWN (1) with bus_own high. Each transfer then runs T1 (3), T2 (4), T3 (5), one WAIT (6) per cycle in which sys_rdy is low at T3 or WAIT, then T4 (7).
- R3: In cycle-steal mode (cfg_burst=0), a SETUP phase (2) comes directly before every T1.
- R4: In burst mode (cfg_burst=1), SETUP comes only before the first transfer and before a transfer that follows an increment where address[15:0]+STEP exceeds 16'hFFFF.
- R5: Each T4 without error adds STEP (2) to bus_addr and subtracts 1 from xfer_left. When xfer_left reaches 0, the next phase is IDLE with bus_own low.
- R6: sys_rls has no effect while bus_own is low, including in IDLE and PAUSE (8).
- R7: sys_rls seen after a cycle has begun lets the cycle reach T4. The next phase is PAUSE with bus_own low, and xfer_left counts only completed transfers. A run_resume pulse in PAUSE continues the run.
- R8: sys_rls seen in OWN, before any cycle, leads directly to PAUSE without entering T1.
- R9: sys_err in T1, T2, T3 or WAIT makes the next phase T4, whatever the state of sys_rdy. That transfer does not count as completed.
- R10: After an errored T4, a non-zero retry count is decremented and the same transfer is run again. A zero retry count leads to HALT (9) with bus_own low.
- R11: err_flag is set by every accepted bus error and holds until err_clr. An err_clr pulse in HALT returns the block to IDLE.
- R12: local_halt follows the HALT condition into the local_clk domain through a two-stage synchroniser, within a few local clock cycles.
- R13: sys_err is ignored in IDLE, OWN, SETUP, T4 and PAUSE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low reset, system domain |
| cfg_start | input | 1 | Start pulse, taken in IDLE with non-zero length |
| cfg_burst | input | 1 | 1 = burst mode, 0 = cycle-steal mode |
| cfg_addr | input | AW | Start address |
| cfg_len | input | LW | Number of transfers |
| cfg_retry | input | RW | Retry budget for bus errors |
| run_resume | input | 1 | Continue a paused run |
| err_clr | input | 1 | Clears err_flag and leaves HALT |
| sys_rdy | input | 1 | Bus ready, ends wait phases |
| sys_rls | input | 1 | Request to give up the bus |
| sys_err | input | 1 | Bus error |
| bus_own | output | 1 | Block owns the system bus |
| bus_phase | output | 4 | Current phase code |
| bus_addr | output | AW | Current transfer address |
| xfer_left | output | LW | Transfers still to run |
| err_flag | output | 1 | Sticky bus-error flag |
| local_clk | input | 1 | Local-side clock |
| local_rst_n | input | 1 | Active-low reset, local domain |
| local_halt | output | 1 | Halt indication in the local domain |

## Verification
The hardest case to reach is the burst-mode setup phase that is inserted again after a carry out of address bit 15, partway through a run. The sweep therefore starts runs just below a 64 KiB boundary, both with and without upper address bits, and in both modes and across several lengths and wait counts. The bench counts every SETUP, WAIT and owned cycle and compares them with totals it works out from the address arithmetic. The error and release cases are driven from the phase the bench sees at the port. That phase picks the exact transfer, and the exact phase within it, at which sys_err or sys_rls is raised.

// File: rtl/dma_rel_pkg.sv
`timescale 1ns/1ps
package dma_rel_pkg;

  typedef enum logic [3:0] {
    PH_IDLE  = 4'd0,
    PH_OWN   = 4'd1,
    PH_SETUP = 4'd2,
    PH_T1    = 4'd3,
    PH_T2    = 4'd4,
    PH_T3    = 4'd5,
    PH_WAIT  = 4'd6,
    PH_T4    = 4'd7,
    PH_PAUSE = 4'd8,
    PH_HALT  = 4'd9
  } phase_e;

  // phases in which a bus error is accepted
  function automatic logic in_bus_cycle(input phase_e p);
    return (p == PH_T1) || (p == PH_T2) || (p == PH_T3) || (p == PH_WAIT);
  endfunction

  // phases in which the bus is held
  function automatic logic owns_bus(input phase_e p);
    return (p == PH_OWN) || (p == PH_SETUP) || in_bus_cycle(p) || (p == PH_T4);
  endfunction

  // carry out of the low half-word on an address step
  function automatic logic low_carry(input logic [15:0] lo, input logic [15:0] step);
    logic [16:0] s;
    s = {1'b0, lo} + {1'b0, step};
    return s[16];
  endfunction

  // whether the next transfer opens with an address-setup phase
  function automatic logic need_setup(input logic burst, input logic due);
    return !burst || due;
  endfunction

endpackage

// File: rtl/dma_rel_dp.sv
`timescale 1ns/1ps
module dma_rel_dp
  import dma_rel_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int RW   = 4,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] cfg_addr,
  input  logic [LW-1:0] cfg_len,
  input  logic [RW-1:0] cfg_retry,
  input  logic          xfer_ok,
  input  logic          retry_take,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] left,
  output logic [RW-1:0] retry_left,
  output logic          carry_now,
  output logic          last_xfer,
  output logic          retry_zero
);
  localparam logic [AW-1:0] STEP_A  = AW'(STEP);
  localparam logic [15:0]   STEP_LO = 16'(STEP);
  localparam logic [LW-1:0] ONE_L   = LW'(1);
  localparam logic [RW-1:0] ONE_R   = RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr       <= '0;
      left       <= '0;
      retry_left <= '0;
    end else if (load) begin
      addr       <= cfg_addr;
      left       <= cfg_len;
      retry_left <= cfg_retry;
    end else begin
      if (xfer_ok) begin
        addr <= addr + STEP_A;
        left <= left - ONE_L;
      end
      if (retry_take) retry_left <= retry_left - ONE_R;
    end
  end

  always_comb begin
    carry_now  = low_carry(addr[15:0], STEP_LO);
    last_xfer  = (left == ONE_L);
    retry_zero = (retry_left == '0);
  end
endmodule

// File: rtl/dma_rel_seq.sv
`timescale 1ns/1ps
module dma_rel_seq
  import dma_rel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_go,
  input  logic   cfg_burst,
  input  logic   resume,
  input  logic   err_clr,
  input  logic   sys_rdy,
  input  logic   sys_rls,
  input  logic   sys_err,
  input  logic   last_xfer,
  input  logic   retry_zero,
  input  logic   carry_now,
  output phase_e phase,
  output logic   load,
  output logic   xfer_ok,
  output logic   retry_take,
  output logic   err_hit,
  output logic   err_seen,
  output logic   rls_pend,
  output logic   burst_q,
  output logic   err_flag,
  output logic   halt_q
);
  phase_e nxt;
  logic   rls_any;
  logic   tx_due;

  always_comb begin
    load       = (phase == PH_IDLE) && start_go;
    err_hit    = in_bus_cycle(phase) && sys_err;
    rls_any    = rls_pend || sys_rls;
    xfer_ok    = (phase == PH_T4) && !err_seen;
    retry_take = (phase == PH_T4) && err_seen && !retry_zero;
    nxt        = phase;
    case (phase)
      PH_IDLE:  if (load) nxt = PH_OWN;
      PH_OWN: begin
        if (rls_any) nxt = PH_PAUSE;
        else         nxt = need_setup(burst_q, tx_due) ? PH_SETUP : PH_T1;
      end
      PH_SETUP: nxt = PH_T1;
      PH_T1:    nxt = sys_err ? PH_T4 : PH_T2;
      PH_T2:    nxt = sys_err ? PH_T4 : PH_T3;
      PH_T3:    nxt = (sys_err || sys_rdy) ? PH_T4 : PH_WAIT;
      PH_WAIT:  nxt = (sys_err || sys_rdy) ? PH_T4 : PH_WAIT;
      PH_T4: begin
        if (err_seen) begin
          if (retry_zero)   nxt = PH_HALT;
          else if (rls_any) nxt = PH_PAUSE;
          else              nxt = need_setup(burst_q, tx_due) ? PH_SETUP : PH_T1;
        end else if (last_xfer) begin
          nxt = PH_IDLE;
        end else if (rls_any) begin
          nxt = PH_PAUSE;
        end else begin
          nxt = need_setup(burst_q, carry_now) ? PH_SETUP : PH_T1;
        end
      end
      PH_PAUSE: if (resume) nxt = PH_OWN;
      PH_HALT:  if (err_clr) nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      burst_q  <= 1'b0;
      tx_due   <= 1'b0;
      err_seen <= 1'b0;
      rls_pend <= 1'b0;
      err_flag <= 1'b0;
      halt_q   <= 1'b0;
    end else begin
      phase <= nxt;
      if (load) burst_q <= cfg_burst;
      if (load)         tx_due <= 1'b1;
      else if (xfer_ok) tx_due <= carry_now;
      if (phase == PH_T4) err_seen <= 1'b0;
      else if (err_hit)   err_seen <= 1'b1;
      rls_pend <= owns_bus(phase) && owns_bus(nxt) && rls_any;
      if (err_hit)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
      halt_q <= (nxt == PH_HALT);
    end
  end
endmodule

// File: rtl/dma_rel_sync.sv
`timescale 1ns/1ps
module dma_rel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] sr;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[i] <= 1'b0;
          else        sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[N-1];
endmodule

// File: rtl/dma_bus_release.sv
`timescale 1ns/1ps
module dma_bus_release
  import dma_rel_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int RW          = 4,
  parameter int STEP        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_burst,
  input  logic [AW-1:0] cfg_addr,
  input  logic [LW-1:0] cfg_len,
  input  logic [RW-1:0] cfg_retry,
  input  logic          run_resume,
  input  logic          err_clr,
  input  logic          sys_rdy,
  input  logic          sys_rls,
  input  logic          sys_err,
  output logic          bus_own,
  output logic [3:0]    bus_phase,
  output logic [AW-1:0] bus_addr,
  output logic [LW-1:0] xfer_left,
  output logic          err_flag,
  input  logic          local_clk,
  input  logic          local_rst_n,
  output logic          local_halt
);
  phase_e        phase;
  logic          start_go, load, xfer_ok, retry_take, err_hit, err_seen;
  logic          rls_pend, burst_q, halt_q, carry_now, last_xfer, retry_zero;
  logic [RW-1:0] retry_left;

  assign start_go = cfg_start && (cfg_len != '0);

  dma_rel_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .cfg_burst(cfg_burst),
    .resume(run_resume), .err_clr(err_clr), .sys_rdy(sys_rdy),
    .sys_rls(sys_rls), .sys_err(sys_err), .last_xfer(last_xfer),
    .retry_zero(retry_zero), .carry_now(carry_now), .phase(phase),
    .load(load), .xfer_ok(xfer_ok), .retry_take(retry_take),
    .err_hit(err_hit), .err_seen(err_seen), .rls_pend(rls_pend),
    .burst_q(burst_q), .err_flag(err_flag), .halt_q(halt_q)
  );

  dma_rel_dp #(.AW(AW), .LW(LW), .RW(RW), .STEP(STEP)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .cfg_retry(cfg_retry), .xfer_ok(xfer_ok),
    .retry_take(retry_take), .addr(bus_addr), .left(xfer_left),
    .retry_left(retry_left), .carry_now(carry_now),
    .last_xfer(last_xfer), .retry_zero(retry_zero)
  );

  dma_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(local_clk), .rst_n(local_rst_n), .d(halt_q), .q(local_halt)
  );

  assign bus_phase = phase;
  assign bus_own   = owns_bus(phase);
endmodule

// File: rtl/dma_bus_release_chk.sv
`timescale 1ns/1ps
module dma_bus_release_chk
  import dma_rel_pkg::*;
#(
  parameter int LW = 16,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    phase,
  input logic          bus_own,
  input logic          sys_rls,
  input logic          sys_rdy,
  input logic          sys_err,
  input logic          err_clr,
  input logic          err_flag,
  input logic [LW-1:0] xfer_left,
  input logic [RW-1:0] retry_left,
  input logic          err_seen,
  input logic          rls_pend,
  input logic          burst_q
);
  logic cyc;
  assign cyc = (phase == PH_T1) || (phase == PH_T2) || (phase == PH_T3) || (phase == PH_WAIT);

  AST_RDY_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_T3 || phase == PH_WAIT) && sys_rdy) |=> (phase == PH_T4)); // R2
  AST_STEAL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1 && !burst_q) |-> ($past(phase) == PH_SETUP)); // R3
  AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T4 && !err_seen && xfer_left > 1) |=> (xfer_left == $past(xfer_left) - LW'(1))); // R5
  AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T4 && !err_seen && xfer_left == 1) |=> (phase == PH_IDLE && !bus_own)); // R5
  AST_NO_PEND_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |=> !rls_pend); // R6
  AST_OWN_RLS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OWN && sys_rls) |=> (phase == PH_PAUSE)); // R8
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && sys_err) |=> (phase == PH_T4)); // R9
  AST_RETRY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T4 && err_seen && retry_left != 0) |=> (retry_left == $past(retry_left) - RW'(1))); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R11
  AST_ERR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc && !err_flag) |=> !err_flag); // R13
endmodule

bind dma_bus_release dma_bus_release_chk #(.LW(LW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(bus_phase), .bus_own(bus_own),
  .sys_rls(sys_rls), .sys_rdy(sys_rdy), .sys_err(sys_err), .err_clr(err_clr),
  .err_flag(err_flag), .xfer_left(xfer_left), .retry_left(retry_left),
  .err_seen(err_seen), .rls_pend(rls_pend), .burst_q(burst_q)
);

// File: tb/tb_dma_bus_release.sv
`timescale 1ns/1ps
module tb_dma_bus_release;
  localparam logic [3:0] P_IDLE = 4'd0, P_OWN = 4'd1, P_SETUP = 4'd2, P_T1 = 4'd3,
                         P_T2 = 4'd4, P_T3 = 4'd5, P_WAIT = 4'd6, P_T4 = 4'd7,
                         P_PAUSE = 4'd8, P_HALT = 4'd9;

  logic        clk = 0, local_clk = 0, rst_n = 0, local_rst_n = 0;
  logic        cfg_start = 0, cfg_burst = 0, run_resume = 0, err_clr = 0;
  logic [31:0] cfg_addr = 0;
  logic [15:0] cfg_len = 0;
  logic [3:0]  cfg_retry = 0;
  logic        sys_rdy = 0, sys_rls = 0, sys_err = 0;
  logic        bus_own, err_flag, local_halt;
  logic [3:0]  bus_phase;
  logic [31:0] bus_addr;
  logic [15:0] xfer_left;

  int checks = 0, errors = 0;
  int n_tx, n_t1, n_t4, n_tw, n_own, end_own;
  logic [3:0] end_ph;

  always #10 clk = ~clk;
  always #15 local_clk = ~local_clk;

  dma_bus_release dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_run(input logic burst, input logic [31:0] a, input logic [15:0] n,
                           input logic [3:0] r);
    @(negedge clk);
    cfg_burst = burst; cfg_addr = a; cfg_len = n; cfg_retry = r; cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
  endtask

  task automatic do_resume();
    @(negedge clk); run_resume = 1;
    @(negedge clk); run_resume = 0;
  endtask

  // emode: 0 none, 1 err at every T2, 2 err at WAIT, 3 err at first T2 only, 4 err outside cycle
  // rls_at: -1 at OWN, k>0 at T2 of transfer k, 0 never
  task automatic watch(input int w, input int rls_at, input int emode);
    int tw_c;
    n_tx = 0; n_t1 = 0; n_t4 = 0; n_tw = 0; n_own = 0; tw_c = 0;
    for (int c = 0; c < 2000; c++) begin
      sys_rdy = 0; sys_rls = 0; sys_err = 0;
      if (bus_phase == P_IDLE || bus_phase == P_PAUSE || bus_phase == P_HALT) begin
        end_ph = bus_phase; end_own = int'(bus_own);
        break;
      end
      if (bus_own) n_own++;
      case (bus_phase)
        P_OWN:   begin if (rls_at == -1) sys_rls = 1; if (emode == 4) sys_err = 1; end
        P_SETUP: begin n_tx++; if (emode == 4) sys_err = 1; end
        P_T1:    begin n_t1++; tw_c = 0; end
        P_T2: begin
          if (rls_at > 0 && rls_at == n_t1) sys_rls = 1;
          if (emode == 1 || (emode == 3 && n_t1 == 1)) sys_err = 1;
        end
        P_T3:    sys_rdy = (w == 0);
        P_WAIT: begin
          n_tw++; tw_c++; sys_rdy = (tw_c >= w);
          if (emode == 2) sys_err = 1;
        end
        P_T4:    begin n_t4++; if (emode == 4) sys_err = 1; end
        default: ;
      endcase
      @(negedge clk);
    end
  endtask

  function automatic int exp_setups(input logic burst, input logic [31:0] a, input int n, input int step);
    int s;
    if (!burst) return n;
    s = 1;
    for (int k = 1; k < n; k++)
      if (((a + 32'(k * step)) & 32'hFFFF) < 32'(step)) s++;
    return s;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] addrs [3];
    int lens [3];
    addrs[0] = 32'h0000_0000; addrs[1] = 32'h0000_FFFA; addrs[2] = 32'h1234_FFFE;
    lens[0] = 1; lens[1] = 3; lens[2] = 6;
    repeat (3) @(negedge clk);
    rst_n = 1; local_rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 phase", bus_phase, P_IDLE);
    chk("R1 own", bus_own, 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 local_halt", local_halt, 0);

    // R2 R3 R4 R5 sweep
    for (int m = 0; m < 2; m++)
      for (int ai = 0; ai < 3; ai++)
        for (int li = 0; li < 3; li++)
          for (int w = 0; w <= 2; w += 2) begin
            int tx;
            start_run(m[0], addrs[ai], 16'(lens[li]), 0);
            chk("R2 own at start", bus_own, 1);
            watch(w, 0, 0);
            tx = exp_setups(m[0], addrs[ai], lens[li], 2);
            chk(m == 0 ? "R3 setup count" : "R4 setup count", n_tx, tx);
            chk("R2 wait count", n_tw, lens[li] * w);
            chk("R2 owned cycles", n_own, 1 + tx + lens[li] * (4 + w));
            chk("R5 end phase", end_ph, P_IDLE);
            chk("R5 own dropped", end_own, 0);
            chk("R5 final addr", bus_addr, addrs[ai] + 32'(2 * lens[li]));
            chk("R5 left zero", xfer_left, 0);
          end

    // R6 release ignored when not owning
    @(negedge clk); sys_rls = 1;
    repeat (3) @(negedge clk);
    sys_rls = 0;
    start_run(0, 32'h100, 2, 0);
    watch(0, 0, 0);
    chk("R6 idle rls ignored end", end_ph, P_IDLE);
    chk("R6 idle rls ignored t4", n_t4, 2);

    // R7 release mid-run, then R6 in PAUSE, resume
    start_run(0, 32'h200, 4, 0);
    watch(1, 2, 0);
    chk("R7 paused", end_ph, P_PAUSE);
    chk("R7 own low", end_own, 0);
    chk("R7 t4 done", n_t4, 2);
    chk("R7 left", xfer_left, 2);
    sys_rls = 1;
    repeat (3) @(negedge clk);
    chk("R6 pause holds", bus_phase, P_PAUSE);
    sys_rls = 0;
    do_resume();
    watch(1, 0, 0);
    chk("R7 resumed end", end_ph, P_IDLE);
    chk("R7 resumed t4", n_t4, 2);
    chk("R7 resumed addr", bus_addr, 32'h208);

    // R8 release before any cycle
    start_run(1, 32'h300, 3, 0);
    watch(0, -1, 0);
    chk("R8 paused", end_ph, P_PAUSE);
    chk("R8 no T1", n_t1, 0);
    chk("R8 left", xfer_left, 3);
    do_resume();
    watch(0, 0, 0);
    chk("R8 resumed end", end_ph, P_IDLE);
    chk("R8 resumed setups", n_tx, 1);

    // R13 errors outside cycles ignored
    @(negedge clk); sys_err = 1;
    repeat (3) @(negedge clk);
    sys_err = 0;
    start_run(0, 32'h400, 2, 0);
    watch(0, 0, 4);
    chk("R13 flag clear", err_flag, 0);
    chk("R13 end", end_ph, P_IDLE);
    chk("R13 t4", n_t4, 2);

    // R10 R11 R12 retries exhausted
    start_run(0, 32'h500, 3, 2);
    watch(0, 0, 1);
    chk("R10 attempts", n_t4, 3);
    chk("R10 halt", end_ph, P_HALT);
    chk("R10 own low", end_own, 0);
    chk("R11 flag set", err_flag, 1);
    repeat (5) @(posedge local_clk);
    @(negedge clk);
    chk("R12 local halt", local_halt, 1);
    chk("R11 flag held", err_flag, 1);
    err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk("R11 cleared", err_flag, 0);
    chk("R11 idle", bus_phase, P_IDLE);
    repeat (5) @(posedge local_clk);
    @(negedge clk);
    chk("R12 local halt gone", local_halt, 0);

    // R9 error in WAIT with ready low
    start_run(1, 32'h600, 2, 0);
    watch(100, 0, 2);
    chk("R9 one wait", n_tw, 1);
    chk("R9 t4", n_t4, 1);
    chk("R9 halt", end_ph, P_HALT);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;

    // R10 single retry then success
    start_run(1, 32'h700, 2, 1);
    watch(0, 0, 3);
    chk("R10 retried t4", n_t4, 3);
    chk("R10 retried t1", n_t1, 3);
    chk("R10 retried end", end_ph, P_IDLE);
    chk("R11 flag after retry", err_flag, 1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk("R11 cleared idle", err_flag, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule